// File: doc/BRIEF.md
# Progressive Supply Escalation Controller

This block runs the digital side of a supply-tuning pass for a low-voltage region that holds several timing-critical paths. At power-on, and again whenever a tune is requested, it starts an external pseudo-random vector source for a programmed number of cycles. During that window it gathers the timing-warning flags raised by the flip-flop sensors on each monitored path. It then decides how much extra supply the warned paths need, applies that choice, waits for the supplies to settle and tests again.

The escalation has three tiers. A single-path block is a group of gates on one critical path. When few paths warn, only the single-path blocks of those paths are switched onto a shared local regulator, and no more of them than that regulator can feed. When more blocks need help than it can feed, a second regulator is enabled. That regulator is wired with no switch to a multi-path block shared by the warned paths. When most paths warn, or neither local tier can change anything, the global low-supply code is raised one step and every local regulator and switch is released. The local supply sits a programmed number of 10 mV steps above the global one, and may never be more than 150 mV above it.

The run ends after a window with no warnings. It ends with a failure flag when a further raise is needed at the programmed ceiling. The final setting is then held until the next request.

Top module: `supply_escalation_ctrl`

## Requirements
- R1: After reset, every block switch and both regulator enables are low and `tune_done` is low, and a tuning run starts without any `tune_req`.
- R2: Path p belongs to the single-path block named by the 2-bit field `cfg_path_blk[2p+1:2p]`. When the set of blocks holding warned paths fits within SW_CAP (1), exactly those blocks are switched on, `shr_reg_en` is high and `mp_reg_en` is low. No more than SW_CAP switch enables are ever high at once.
- R3: When the warned paths span more blocks than SW_CAP, the lowest-numbered SW_CAP of those blocks are switched on. `mp_reg_en` is also raised if at least one warned path has its bit set in `cfg_mp_member`.
- R4: When the number of warned paths is at least RAISE_AT (more than two thirds of the paths; 3 of 3 by default), or when the local setting it computes equals the one in place, the global code rises by one. All switch and regulator enables then drop, and the accumulated warning set is cleared.
- R5: A configuration is rejected if the offset exceeds 15 steps (150 mV over 10 mV), the window length is zero, the initial code exceeds the ceiling, or a block field is 3 or more. On rejection `cfg_reject` and `tune_done` rise, no window is run, all local enables are low and the global code is unchanged.
- R6: `vloc_code` always equals `vlow_code` plus the accepted offset, and is never more than 15 steps above it.
- R7: Each test window holds `tvg_run` high for exactly `cfg_win_len` consecutive cycles. A warning seen in any cycle of the window counts for that window only.
- R8: Between two windows of one run, `tvg_run` stays low for exactly `cfg_settle_len` + 2 cycles.
- R9: A window with no warnings ends the run with `tune_done` high and `tune_fail` low. If a raise is needed while the code equals `cfg_code_max`, the run ends with both high and the code left at the ceiling.
- R10: While `tune_done` is high and no request arrives, all outputs hold. A `tune_req` clears the flags and reruns from `cfg_code_init`.
- R11: The warning set used for local decisions is the union of all windows since the run began or since the last global raise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_req | input | 1 | Periodic tune request, sampled while idle |
| path_warn | input | NUM_PATHS | Timing-warning flag per monitored path |
| cfg_path_blk | input | NUM_PATHS*BIW | Single-path block index per path |
| cfg_mp_member | input | NUM_PATHS | Path lies in the multi-path block |
| cfg_win_len | input | WIN_W | Test window length in cycles |
| cfg_settle_len | input | SET_W | Settling wait after a change |
| cfg_code_init | input | CODE_W | Starting global low-supply code |
| cfg_code_max | input | CODE_W | Ceiling of the global code |
| cfg_loc_offset | input | CODE_W | Local supply offset in 10 mV steps |
| tvg_run | output | 1 | Runs the test-vector source |
| blk_sw_en | output | NUM_BLKS | Switch enable per single-path block |
| shr_reg_en | output | 1 | Shared local regulator enable |
| mp_reg_en | output | 1 | Multi-path block regulator enable |
| vlow_code | output | CODE_W | Global low-supply code |
| vloc_code | output | CODE_W+1 | Local supply code |
| tune_done | output | 1 | Run finished, result held |
| tune_fail | output | 1 | Ceiling reached with warnings left |
| cfg_reject | output | 1 | Configuration refused |

## Verification
Directed patterns pin down each tier on its own. A single warning selects one block. Two warnings in separate blocks bring in the multi-path regulator. Two warnings inside one block stay in the first tier. Three warnings force a global raise. A warning set that repeats with no multi-path membership shows the no-progress fallback to a raise, and two windows that each warn on one different path show that the warning set accumulates across windows. Constrained random runs then mix maps, memberships, window and settle lengths and ceilings, so that successful finishes, failures at the ceiling and repeated raises all occur. Each run is compared with a step-by-step model, and the window and gap lengths are measured. Boundary offsets of 15 and 16 steps and each kind of bad configuration show the accept and reject edge.

// File: rtl/sec_pkg.sv
package sec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SETTLE,
    ST_WIN,
    ST_DECIDE
  } sec_state_e;
endpackage

// File: rtl/sec_rst_sync.sv
module sec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sec_timer.sv
module sec_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = load_val;
    else if (dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sec_warn_sticky.sv
module sec_warn_sticky #(
  parameter int NP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap,
  input  logic [NP-1:0] warn,
  output logic [NP-1:0] flags
);
  logic [NP-1:0] flg_q, flg_d;

  always_comb begin
    flg_d = flg_q;
    if (clr)      flg_d = '0;
    else if (cap) flg_d = flg_q | warn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags = flg_q;
endmodule

// File: rtl/sec_tier_select.sv
module sec_tier_select #(
  parameter int NP       = 3,
  parameter int NB       = 3,
  parameter int BIW      = 2,
  parameter int SW_CAP   = 1,
  parameter int RAISE_AT = 3
) (
  input  logic [NP-1:0]     need,
  input  logic [NP*BIW-1:0] map,
  input  logic [NP-1:0]     mp_member,
  input  logic [NB-1:0]     cur_sw,
  input  logic              cur_mp,
  output logic [NB-1:0]     nxt_sw,
  output logic              nxt_mp,
  output logic              raise
);
  logic [NB-1:0] blk_need;
  int            n_paths;
  int            n_blks;
  int            taken;

  always_comb begin
    blk_need = '0;
    n_paths  = 0;
    for (int p = 0; p < NP; p++) begin
      if (need[p]) begin
        n_paths = n_paths + 1;
        for (int b = 0; b < NB; b++) begin
          if (int'(map[p*BIW +: BIW]) == b) blk_need[b] = 1'b1;
        end
      end
    end
    n_blks = 0;
    taken  = 0;
    nxt_sw = '0;
    for (int b = 0; b < NB; b++) begin
      if (blk_need[b]) begin
        n_blks = n_blks + 1;
        if (taken < SW_CAP) begin
          nxt_sw[b] = 1'b1;
          taken     = taken + 1;
        end
      end
    end
    nxt_mp = (n_blks > SW_CAP) && |(need & mp_member);
    raise  = (n_paths >= RAISE_AT) || ((nxt_sw == cur_sw) && (nxt_mp == cur_mp));
  end
endmodule

// File: rtl/supply_escalation_ctrl.sv
module supply_escalation_ctrl
  import sec_pkg::*;
#(
  parameter int  NUM_PATHS    = 3,
  parameter int  NUM_BLKS     = 3,
  parameter int  SW_CAP       = 1,
  parameter int  CODE_W       = 6,
  parameter int  WIN_W        = 8,
  parameter int  SET_W        = 6,
  parameter int  STEP_MV      = 10,
  parameter int  MAX_DELTA_MV = 150,
  localparam int BIW          = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1,
  localparam int TMR_W        = (WIN_W > SET_W) ? WIN_W : SET_W,
  localparam int OFF_LIMIT    = MAX_DELTA_MV / STEP_MV,
  localparam int RAISE_AT     = (2 * NUM_PATHS) / 3 + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tune_req,
  input  logic [NUM_PATHS-1:0]    path_warn,
  input  logic [NUM_PATHS*BIW-1:0] cfg_path_blk,
  input  logic [NUM_PATHS-1:0]    cfg_mp_member,
  input  logic [WIN_W-1:0]        cfg_win_len,
  input  logic [SET_W-1:0]        cfg_settle_len,
  input  logic [CODE_W-1:0]       cfg_code_init,
  input  logic [CODE_W-1:0]       cfg_code_max,
  input  logic [CODE_W-1:0]       cfg_loc_offset,
  output logic                    tvg_run,
  output logic [NUM_BLKS-1:0]     blk_sw_en,
  output logic                    shr_reg_en,
  output logic                    mp_reg_en,
  output logic [CODE_W-1:0]       vlow_code,
  output logic [CODE_W:0]         vloc_code,
  output logic                    tune_done,
  output logic                    tune_fail,
  output logic                    cfg_reject
);
  logic rst_i_n;

  sec_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  sec_state_e               state_q, state_d;
  logic [CODE_W-1:0]        vcode_q, vcode_d;
  logic [NUM_BLKS-1:0]      sw_q, sw_d;
  logic                     mp_q, mp_d, shr_q, shr_d;
  logic [NUM_PATHS-1:0]     acc_q, acc_d;
  logic                     done_q, done_d, fail_q, fail_d, rej_q, rej_d;
  logic [NUM_PATHS*BIW-1:0] map_q, map_d;
  logic [NUM_PATHS-1:0]     mask_q, mask_d;
  logic [WIN_W-1:0]         win_q, win_d;
  logic [SET_W-1:0]         set_q, set_d;
  logic [CODE_W-1:0]        max_q, max_d, off_q, off_d;

  logic                 tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0]     tmr_val;
  logic                 stk_clr, stk_cap;
  logic [NUM_PATHS-1:0] stk_flags, need;
  logic [NUM_BLKS-1:0]  nxt_sw;
  logic                 nxt_mp, do_raise;
  logic [NUM_PATHS-1:0] map_ok;
  logic                 cfg_ok;

  // block field range check per path
  generate
    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_map_chk
      assign map_ok[p] = (int'(cfg_path_blk[p*BIW +: BIW]) < NUM_BLKS);
    end
  endgenerate

  assign cfg_ok = (&map_ok) && (int'(cfg_loc_offset) <= OFF_LIMIT) &&
                  (cfg_win_len != '0) && (cfg_code_init <= cfg_code_max);

  assign need = acc_q | stk_flags;

  sec_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .load(tmr_load), .dec(tmr_dec),
    .load_val(tmr_val), .zero(tmr_zero)
  );

  sec_warn_sticky #(.NP(NUM_PATHS)) u_stk (
    .clk(clk), .rst_n(rst_i_n), .clr(stk_clr), .cap(stk_cap),
    .warn(path_warn), .flags(stk_flags)
  );

  sec_tier_select #(
    .NP(NUM_PATHS), .NB(NUM_BLKS), .BIW(BIW), .SW_CAP(SW_CAP), .RAISE_AT(RAISE_AT)
  ) u_tier (
    .need(need), .map(map_q), .mp_member(mask_q), .cur_sw(sw_q), .cur_mp(mp_q),
    .nxt_sw(nxt_sw), .nxt_mp(nxt_mp), .raise(do_raise)
  );

  always_comb begin
    state_d  = state_q;
    vcode_d  = vcode_q;
    sw_d     = sw_q;
    mp_d     = mp_q;
    shr_d    = shr_q;
    acc_d    = acc_q;
    done_d   = done_q;
    fail_d   = fail_q;
    rej_d    = rej_q;
    map_d    = map_q;
    mask_d   = mask_q;
    win_d    = win_q;
    set_d    = set_q;
    max_d    = max_q;
    off_d    = off_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    tmr_val  = '0;
    stk_clr  = 1'b0;
    stk_cap  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tune_req) begin
          state_d = ST_START;
          done_d  = 1'b0;
          fail_d  = 1'b0;
          rej_d   = 1'b0;
        end
      end
      ST_START: begin
        sw_d  = '0;
        mp_d  = 1'b0;
        shr_d = 1'b0;
        acc_d = '0;
        if (cfg_ok) begin
          map_d    = cfg_path_blk;
          mask_d   = cfg_mp_member;
          win_d    = cfg_win_len;
          set_d    = cfg_settle_len;
          max_d    = cfg_code_max;
          off_d    = cfg_loc_offset;
          vcode_d  = cfg_code_init;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(cfg_settle_len);
          state_d  = ST_SETTLE;
        end else begin
          rej_d   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_SETTLE: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(win_q) - TMR_W'(1);
          stk_clr  = 1'b1;
          state_d  = ST_WIN;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_WIN: begin
        stk_cap = 1'b1;
        if (tmr_zero) state_d = ST_DECIDE;
        else          tmr_dec = 1'b1;
      end
      ST_DECIDE: begin
        if (stk_flags == '0) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (do_raise) begin
          if (vcode_q == max_q) begin
            fail_d  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            vcode_d  = vcode_q + 1'b1;
            sw_d     = '0;
            mp_d     = 1'b0;
            shr_d    = 1'b0;
            acc_d    = '0;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(set_q);
            state_d  = ST_SETTLE;
          end
        end else begin
          sw_d     = nxt_sw;
          mp_d     = nxt_mp;
          shr_d    = 1'b1;
          acc_d    = need;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(set_q);
          state_d  = ST_SETTLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_START;
      vcode_q <= '0;
      sw_q    <= '0;
      mp_q    <= 1'b0;
      shr_q   <= 1'b0;
      acc_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      rej_q   <= 1'b0;
      map_q   <= '0;
      mask_q  <= '0;
      win_q   <= '0;
      set_q   <= '0;
      max_q   <= '0;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      vcode_q <= vcode_d;
      sw_q    <= sw_d;
      mp_q    <= mp_d;
      shr_q   <= shr_d;
      acc_q   <= acc_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      rej_q   <= rej_d;
      map_q   <= map_d;
      mask_q  <= mask_d;
      win_q   <= win_d;
      set_q   <= set_d;
      max_q   <= max_d;
      off_q   <= off_d;
    end
  end

  assign tvg_run    = (state_q == ST_WIN);
  assign blk_sw_en  = sw_q;
  assign shr_reg_en = shr_q;
  assign mp_reg_en  = mp_q;
  assign vlow_code  = vcode_q;
  assign vloc_code  = {1'b0, vcode_q} + {1'b0, off_q};
  assign tune_done  = done_q;
  assign tune_fail  = fail_q;
  assign cfg_reject = rej_q;
endmodule

// File: rtl/sec_checker.sv
module sec_checker #(
  parameter int NUM_BLKS  = 3,
  parameter int SW_CAP    = 1,
  parameter int CODE_W    = 6,
  parameter int OFF_LIMIT = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tune_req,
  input logic                tvg_run,
  input logic [NUM_BLKS-1:0] blk_sw_en,
  input logic                shr_reg_en,
  input logic                mp_reg_en,
  input logic [CODE_W-1:0]   vlow_code,
  input logic [CODE_W:0]     vloc_code,
  input logic                tune_done,
  input logic                tune_fail,
  input logic                cfg_reject
);
  assert_sw_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(blk_sw_en) <= SW_CAP);

  assert_mp_needs_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mp_reg_en |-> (shr_reg_en && $countones(blk_sw_en) == SW_CAP));

  assert_raise_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vlow_code == $past(vlow_code) + 1'b1) |-> (!shr_reg_en && !mp_reg_en && blk_sw_en == '0));

  assert_reject_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject |-> (tune_done && !tvg_run && blk_sw_en == '0 && !mp_reg_en));

  assert_offset_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(vloc_code) - int'(vlow_code)) <= OFF_LIMIT);

  assert_fail_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tune_fail |-> (tune_done && !tvg_run));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_done && !tune_req) |=> (tune_done && $stable(vlow_code) && $stable(blk_sw_en) &&
                                  $stable(mp_reg_en) && $stable(shr_reg_en)));
endmodule

bind supply_escalation_ctrl sec_checker #(
  .NUM_BLKS(NUM_BLKS), .SW_CAP(SW_CAP), .CODE_W(CODE_W), .OFF_LIMIT(OFF_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tune_req(tune_req), .tvg_run(tvg_run),
  .blk_sw_en(blk_sw_en), .shr_reg_en(shr_reg_en), .mp_reg_en(mp_reg_en),
  .vlow_code(vlow_code), .vloc_code(vloc_code), .tune_done(tune_done),
  .tune_fail(tune_fail), .cfg_reject(cfg_reject)
);

// File: tb/supply_escalation_ctrl_tb.sv
module supply_escalation_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tune_req;
  logic [2:0] path_warn;
  logic [5:0] cfg_path_blk;
  logic [2:0] cfg_mp_member;
  logic [7:0] cfg_win_len;
  logic [5:0] cfg_settle_len;
  logic [5:0] cfg_code_init, cfg_code_max, cfg_loc_offset;
  logic       tvg_run;
  logic [2:0] blk_sw_en;
  logic       shr_reg_en, mp_reg_en;
  logic [5:0] vlow_code;
  logic [6:0] vloc_code;
  logic       tune_done, tune_fail, cfg_reject;

  always #10 clk = ~clk;

  supply_escalation_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tune_req(tune_req), .path_warn(path_warn),
    .cfg_path_blk(cfg_path_blk), .cfg_mp_member(cfg_mp_member),
    .cfg_win_len(cfg_win_len), .cfg_settle_len(cfg_settle_len),
    .cfg_code_init(cfg_code_init), .cfg_code_max(cfg_code_max),
    .cfg_loc_offset(cfg_loc_offset), .tvg_run(tvg_run), .blk_sw_en(blk_sw_en),
    .shr_reg_en(shr_reg_en), .mp_reg_en(mp_reg_en), .vlow_code(vlow_code),
    .vloc_code(vloc_code), .tune_done(tune_done), .tune_fail(tune_fail),
    .cfg_reject(cfg_reject)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [2:0] pat [16];

  // model state
  logic [2:0] m_sw, m_acc;
  logic       m_mp, m_shr, m_done, m_fail;
  int         m_vc, m_nwin;

  // monitor state
  int mon_wins, mon_hi, mon_lo;
  bit mon_prev, mon_fell;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // window driver and length monitor (R7, R8)
  always @(negedge clk) begin
    if (!rst_n || tune_req) begin
      mon_wins = 0; mon_hi = 0; mon_lo = 0; mon_prev = 0; mon_fell = 0;
      path_warn = '0;
    end else begin
      if (tvg_run) begin
        if (!mon_prev) begin
          mon_wins++;
          if (mon_fell) chk("R8 settle gap", mon_lo, int'(cfg_settle_len) + 2);
          mon_hi = 0;
        end
        mon_hi++;
        path_warn = (mon_wins <= 16) ? pat[mon_wins-1] : 3'b000;
      end else begin
        if (mon_prev) begin
          chk("R7 window length", mon_hi, int'(cfg_win_len));
          mon_fell = 1;
          mon_lo = 0;
          path_warn = '0;
        end
        mon_lo++;
      end
      mon_prev = tvg_run;
    end
  end

  function automatic int blk_of(input int p);
    return int'(cfg_path_blk[2*p +: 2]);
  endfunction

  task automatic model_win(input logic [2:0] w);
    logic [2:0] need, bn, sel;
    logic       mp;
    int         cnt;
    if (w == 3'b000) begin m_done = 1; m_nwin++; return; end
    need = m_acc | w;
    cnt = $countones(need);
    bn = '0;
    for (int p = 0; p < 3; p++) if (need[p]) bn[blk_of(p)] = 1'b1;
    sel = '0;
    for (int b = 2; b >= 0; b--) if (bn[b]) sel = 3'b001 << b;
    mp = ($countones(bn) > 1) && |(need & cfg_mp_member);
    if (cnt >= 3 || (sel == m_sw && mp == m_mp)) begin
      if (m_vc == int'(cfg_code_max)) begin
        m_fail = 1; m_done = 1;
      end else begin
        m_vc++; m_sw = '0; m_mp = 0; m_shr = 0; m_acc = '0;
      end
    end else begin
      m_sw = sel; m_mp = mp; m_shr = 1; m_acc = need;
    end
    m_nwin++;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    @(negedge clk);
    while (tune_done && t < 10) begin @(negedge clk); t++; end
    t = 0;
    while (!tune_done && t < 4000) begin @(negedge clk); t++; end
    if (!tune_done) begin
      n_fail++;
      $display("FAIL R9 %s: actual done=0 expected done=1 (timeout)", tag);
    end
  endtask

  task automatic request();
    @(posedge clk); #1 tune_req = 1'b1;
    @(posedge clk); #1 tune_req = 1'b0;
  endtask

  task automatic set_pats(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
    for (int i = 0; i < 16; i++) pat[i] = 3'b000;
    pat[0] = a; pat[1] = b; pat[2] = c;
  endtask

  task automatic check_result(input string tag);
    m_sw = '0; m_mp = 0; m_shr = 0; m_acc = '0; m_done = 0; m_fail = 0;
    m_vc = int'(cfg_code_init); m_nwin = 0;
    for (int i = 0; i < 16; i++) if (!m_done) model_win(pat[i]);
    chk({tag, " R2 switch enables"}, blk_sw_en, m_sw);
    chk({tag, " R3 multi-path regulator"}, mp_reg_en, m_mp);
    chk({tag, " R2 shared regulator"}, shr_reg_en, m_shr);
    chk({tag, " R4 global code"}, vlow_code, m_vc);
    chk({tag, " R6 local code"}, vloc_code, m_vc + int'(cfg_loc_offset));
    chk({tag, " R9 fail flag"}, tune_fail, m_fail);
    chk({tag, " R11 window count"}, mon_wins, m_nwin);
    chk({tag, " R5 no reject"}, cfg_reject, 0);
  endtask

  task automatic run_tune(input string tag);
    request();
    wait_done(tag);
    check_result(tag);
  endtask

  task automatic run_reject(input string tag);
    logic [5:0] vc_before;
    logic [6:0] lc_before;
    vc_before = vlow_code;
    lc_before = vloc_code;
    request();
    wait_done(tag);
    chk({tag, " R5 reject flag"}, cfg_reject, 1);
    chk({tag, " R5 no window"}, mon_wins, 0);
    chk({tag, " R5 locals off"}, {blk_sw_en, shr_reg_en, mp_reg_en}, 0);
    chk({tag, " R5 code kept"}, vlow_code, vc_before);
    chk({tag, " R6 local code kept"}, vloc_code, lc_before);
  endtask

  task automatic base_cfg();
    cfg_path_blk = {2'd2, 2'd1, 2'd0};
    cfg_mp_member = 3'b111;
    cfg_win_len = 8'd3;
    cfg_settle_len = 6'd2;
    cfg_code_init = 6'd10;
    cfg_code_max = 6'd20;
    cfg_loc_offset = 6'd15;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [6:0] lc;
    logic [5:0] vc;
    logic [2:0] sw;
    seed = $urandom(32'd4711);
    rst_n = 1'b0;
    tune_req = 1'b0;
    base_cfg();
    set_pats(3'b001, 3'b000, 3'b000);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset defaults
    chk("R1 reset switches", blk_sw_en, 0);
    chk("R1 reset regulators", {shr_reg_en, mp_reg_en}, 0);
    chk("R1 reset done", tune_done, 0);
    // R1 power-on run with no request, offset at 15 steps (R6 boundary)
    wait_done("power-on");
    check_result("R1 power-on one warning");

    // R10 hold while idle
    lc = vloc_code; vc = vlow_code; sw = blk_sw_en;
    repeat (25) @(negedge clk);
    chk("R10 hold done", tune_done, 1);
    chk("R10 hold code", vlow_code, vc);
    chk("R10 hold local", vloc_code, lc);
    chk("R10 hold switches", blk_sw_en, sw);

    set_pats(3'b011, 3'b000, 3'b000);
    run_tune("R3 two warnings");
    set_pats(3'b111, 3'b000, 3'b000);
    run_tune("R4 three warnings");
    set_pats(3'b001, 3'b010, 3'b000);
    run_tune("R11 accumulate");
    cfg_mp_member = 3'b000;
    set_pats(3'b011, 3'b011, 3'b000);
    run_tune("R4 no progress");
    cfg_mp_member = 3'b111;
    cfg_path_blk = {2'd2, 2'd2, 2'd2};
    set_pats(3'b011, 3'b000, 3'b000);
    run_tune("R2 shared block");
    base_cfg();
    cfg_code_init = 6'd5; cfg_code_max = 6'd5;
    set_pats(3'b111, 3'b000, 3'b000);
    run_tune("R9 ceiling");

    base_cfg();
    cfg_loc_offset = 6'd16;
    run_reject("R5 offset 16");
    base_cfg();
    cfg_win_len = 8'd0;
    run_reject("R5 zero window");
    base_cfg();
    cfg_code_init = 6'd21;
    run_reject("R5 init above max");
    base_cfg();
    cfg_path_blk = {2'd0, 2'd3, 2'd0};
    run_reject("R5 bad block field");

    for (int n = 0; n < 40; n++) begin
      int np;
      cfg_path_blk = {2'($urandom % 3), 2'($urandom % 3), 2'($urandom % 3)};
      cfg_mp_member = 3'($urandom);
      cfg_win_len = 8'(1 + $urandom % 4);
      cfg_settle_len = 6'($urandom % 4);
      cfg_code_init = 6'($urandom % 40);
      cfg_code_max = cfg_code_init + 6'($urandom % 4);
      cfg_loc_offset = 6'($urandom % 16);
      for (int i = 0; i < 16; i++) pat[i] = 3'b000;
      np = 1 + $urandom % 6;
      for (int i = 0; i < np; i++) pat[i] = 3'($urandom);
      run_tune("R2 R3 R4 R11 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule